// File: doc/BRIEF.md
# Frequency Synthesizer Divider Configuration Register

This block holds the divider settings that steer a clock synthesizer: a 9-bit loop-divide count, a 2-bit output-divide select and a 3-bit test-select code. It offers two ways to load them. A parallel path captures the count and select from pins when a parallel strobe goes high. A serial path collects a 14-bit word one bit per serial clock and commits it when a serial strobe goes low.

The two paths have a fixed priority. The parallel strobe's rising edge wins over everything else. A serial commit is honoured only while the parallel strobe is high. All strobe and data pins are asynchronous to the system clock. They pass through a synchronizer of `SYNC_STAGES` flops, so a pin event takes effect `SYNC_STAGES + 1` system clocks after it occurs.

Besides the latched settings, the block decodes the output select into a one-hot divide ratio. It also raises a flag when the latched loop count lies outside the lockable window.

Top module: `synth_div_config`

## Requirements
- R1: Each rising edge of `sclk_i` shifts the shift register one place toward its MSB and takes `sdata_i` into bit 0. The first bit shifted of 14 ends in bit 13.
- R2: The serial word layout is: bits 13..11 hold the test code (first bit shifted = its MSB), bits 10..9 hold the output select, and bits 8..0 hold the loop count, LSB shifted last.
- R3: A rising edge of `pload_i` loads `m_pin_i` into `m_o` and `n_pin_i` into `n_o`. `t_o` is left unchanged.
- R4: A falling edge of `sload_i` while `pload_i` is high copies the shift register word into `t_o`, `n_o` and `m_o`.
- R5: A falling edge of `sload_i` while `pload_i` is low leaves all three latched outputs unchanged.
- R6: If a parallel rising edge and a serial falling edge arrive in the same cycle, the parallel load is taken and the serial word is not.
- R7: `ratio_o` is one-hot: select 0 gives 1 (bit 0), 1 gives 2, 2 gives 4 and 3 gives 8.
- R8: `lock_err_o` is high exactly when `m_o` is below 200 or above 400. The values 200 and 400 are legal.
- R9: Asynchronous active-low reset sets `m_o`=200, `n_o`=0, `t_o`=0 and clears the shift register. A `pload_i` that is already high at release causes no load.
- R10: With `m_pin_i` and `n_pin_i` left at their undriven all-ones level, a parallel load yields `m_o`=511, `n_o`=3, ratio 8 and a raised lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous pin) |
| sdata_i | input | 1 | Serial data bit |
| sload_i | input | 1 | Serial commit strobe, acts on falling edge |
| pload_i | input | 1 | Parallel load strobe, acts on rising edge |
| m_pin_i | input | 9 | Parallel loop-divide count |
| n_pin_i | input | 2 | Parallel output-divide select |
| m_o | output | 9 | Latched loop-divide count |
| n_o | output | 2 | Latched output-divide select |
| t_o | output | 3 | Latched test-select code |
| ratio_o | output | 4 | One-hot output divide ratio |
| lock_err_o | output | 1 | Loop count outside 200..400 |

## Verification
The hardest situation to reach is a parallel rising edge and a serial falling edge landing in the same synchronized cycle. The bench reaches it by first holding the parallel strobe low while it shifts a word and raises the serial strobe. It then flips both strobe pins in one assignment, so both edges cross the equal-length synchronizer together. A second serial commit afterwards shows that the shifted word survived the contest. A serial commit straight after reset exposes the cleared shift register through the outputs.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int M_BITS    = 9;
   localparam int N_BITS    = 2;
   localparam int T_BITS    = 3;
   localparam int WORD_BITS = M_BITS + N_BITS + T_BITS;
   // positions inside the synchronized pin vector
   localparam int PIN_SCLK  = 0;
   localparam int PIN_PLOAD = 1;
   localparam int PIN_SLOAD = 2;
   localparam int PIN_SDATA = 3;
   localparam int PIN_COUNT = 4;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
   parameter int           W       = 4,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= RST_VAL;
         end else begin
            if (s == 0) chain_q[s] <= raw_i;
            else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdc_shreg.sv
module sdc_shreg #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         din_i,
   output logic [W-1:0] word_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (shift_i) word_o <= {word_o[W-2:0], din_i};
   end
endmodule

// File: rtl/sdc_latch.sv
module sdc_latch #(
   parameter int M_W   = 9,
   parameter int N_W   = 2,
   parameter int T_W   = 3,
   parameter int M_RST = 200,
   localparam int WW   = M_W + N_W + T_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_evt_i,
   input  logic           ser_evt_i,
   input  logic           par_lvl_i,
   input  logic [M_W-1:0] m_pin_i,
   input  logic [N_W-1:0] n_pin_i,
   input  logic [WW-1:0]  word_i,
   output logic [M_W-1:0] m_o,
   output logic [N_W-1:0] n_o,
   output logic [T_W-1:0] t_o
);
   logic ser_ok;
   assign ser_ok = ser_evt_i & par_lvl_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_o <= M_W'(M_RST);
         n_o <= '0;
         t_o <= '0;
      end else if (par_evt_i) begin
         m_o <= m_pin_i;
         n_o <= n_pin_i;
      end else if (ser_ok) begin
         t_o <= word_i[WW-1 -: T_W];
         n_o <= word_i[M_W +: N_W];
         m_o <= word_i[M_W-1:0];
      end
   end
endmodule

// File: rtl/sdc_decode.sv
module sdc_decode #(
   parameter int M_W  = 9,
   parameter int N_W  = 2,
   parameter int M_LO = 200,
   parameter int M_HI = 400,
   localparam int NCODES = 1 << N_W
) (
   input  logic [M_W-1:0]    m_i,
   input  logic [N_W-1:0]    n_i,
   output logic [NCODES-1:0] ratio_o,
   output logic              lock_err_o
);
   localparam logic [M_W-1:0] LO = M_W'(M_LO);
   localparam logic [M_W-1:0] HI = M_W'(M_HI);

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      assign ratio_o[c] = (n_i == N_W'(c));
   end

   assign lock_err_o = (m_i < LO) || (m_i > HI);
endmodule

// File: rtl/synth_div_config.sv
module synth_div_config
   import sdc_pkg::*;
#(
   parameter int M_W         = M_BITS,
   parameter int N_W         = N_BITS,
   parameter int T_W         = T_BITS,
   parameter int SYNC_STAGES = 2,
   parameter int M_RST       = 200,
   parameter int M_LO        = 200,
   parameter int M_HI        = 400,
   localparam int WW         = M_W + N_W + T_W,
   localparam int NCODES     = 1 << N_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdata_i,
   input  logic              sload_i,
   input  logic              pload_i,
   input  logic [M_W-1:0]    m_pin_i,
   input  logic [N_W-1:0]    n_pin_i,
   output logic [M_W-1:0]    m_o,
   output logic [N_W-1:0]    n_o,
   output logic [T_W-1:0]    t_o,
   output logic [NCODES-1:0] ratio_o,
   output logic              lock_err_o
);
   // elaboration checks
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (M_RST >= (1 << M_W) || M_HI >= (1 << M_W)) begin : g_bad_m
      $error("reset or upper count does not fit M_W");
   end
   if (M_LO > M_HI) begin : g_bad_win
      $error("lock window is empty");
   end

   // strobes idle at the level whose edge they never act on
   localparam logic [PIN_COUNT-1:0] PIN_RST =
      PIN_COUNT'((1 << PIN_SCLK) | (1 << PIN_PLOAD));

   logic [PIN_COUNT-1:0] pin_raw, pin_s;
   logic [2:0]           prev_q;
   logic                 sclk_rise, p_rise, s_fall, p_lvl, sdata_s;
   logic [WW-1:0]        word_q;

   assign pin_raw[PIN_SCLK]  = sclk_i;
   assign pin_raw[PIN_PLOAD] = pload_i;
   assign pin_raw[PIN_SLOAD] = sload_i;
   assign pin_raw[PIN_SDATA] = sdata_i;

   sdc_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(pin_raw), .sync_o(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= PIN_RST[2:0];
      else        prev_q <= pin_s[2:0];
   end

   assign sclk_rise = pin_s[PIN_SCLK]  & ~prev_q[PIN_SCLK];
   assign p_rise    = pin_s[PIN_PLOAD] & ~prev_q[PIN_PLOAD];
   assign s_fall    = ~pin_s[PIN_SLOAD] & prev_q[PIN_SLOAD];
   assign p_lvl     = pin_s[PIN_PLOAD];
   assign sdata_s   = pin_s[PIN_SDATA];

   sdc_shreg #(.W(WW)) u_shreg (
      .clk(clk), .rst_n(rst_n), .shift_i(sclk_rise), .din_i(sdata_s), .word_o(word_q)
   );

   sdc_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .M_RST(M_RST)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .par_evt_i(p_rise), .ser_evt_i(s_fall), .par_lvl_i(p_lvl),
      .m_pin_i(m_pin_i), .n_pin_i(n_pin_i), .word_i(word_q),
      .m_o(m_o), .n_o(n_o), .t_o(t_o)
   );

   sdc_decode #(.M_W(M_W), .N_W(N_W), .M_LO(M_LO), .M_HI(M_HI)) u_decode (
      .m_i(m_o), .n_i(n_o), .ratio_o(ratio_o), .lock_err_o(lock_err_o)
   );
endmodule

// File: rtl/sdc_chk.sv
module sdc_chk
   import sdc_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                sclk_rise,
   input logic                sdata_s,
   input logic                p_rise,
   input logic                s_fall,
   input logic                p_lvl,
   input logic [WORD_BITS-1:0] word_q,
   input logic [M_BITS-1:0]   m_pin_i,
   input logic [N_BITS-1:0]   n_pin_i,
   input logic [M_BITS-1:0]   m_o,
   input logic [N_BITS-1:0]   n_o,
   input logic [T_BITS-1:0]   t_o,
   input logic [(1<<N_BITS)-1:0] ratio_o
);
   // R1
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (word_q[0] == $past(sdata_s)) &&
                    (word_q[WORD_BITS-1:1] == $past(word_q[WORD_BITS-2:0])));
   // R3
   par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_rise |=> (m_o == $past(m_pin_i)) && (n_o == $past(n_pin_i)) && $stable(t_o));
   // R4
   ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_fall && p_lvl && !p_rise) |=> ({t_o, n_o, m_o} == $past(word_q)));
   // R5
   ser_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_fall && !p_lvl && !p_rise) |=> $stable({t_o, n_o, m_o}));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!p_rise && !s_fall) |=> $stable({t_o, n_o, m_o}));
   // R7
   ratio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ratio_o) == 1);
endmodule

bind synth_div_config sdc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sdata_s(sdata_s),
   .p_rise(p_rise), .s_fall(s_fall), .p_lvl(p_lvl), .word_q(word_q),
   .m_pin_i(m_pin_i), .n_pin_i(n_pin_i), .m_o(m_o), .n_o(n_o), .t_o(t_o),
   .ratio_o(ratio_o)
);

// File: tb/synth_div_config_bench.sv
module synth_div_config_bench;
   localparam int CLK_P  = 10;
   localparam int SETTLE = 5;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       sclk_i = 0, sdata_i = 0, sload_i = 0, pload_i = 1;
   logic [8:0] m_pin_i = '1;
   logic [1:0] n_pin_i = '1;
   logic [8:0] m_o;
   logic [1:0] n_o;
   logic [2:0] t_o;
   logic [3:0] ratio_o;
   logic       lock_err_o;

   int checks = 0;
   int fails  = 0;
   int exp_t  = 0;

   always #(CLK_P/2) clk = ~clk;

   synth_div_config u_synth_div_config (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
      .sload_i(sload_i), .pload_i(pload_i), .m_pin_i(m_pin_i), .n_pin_i(n_pin_i),
      .m_o(m_o), .n_o(n_o), .t_o(t_o), .ratio_o(ratio_o), .lock_err_o(lock_err_o)
   );

   // {serial?, T[2:0], N[1:0], M[8:0]}
   localparam logic [14:0] VEC [8] = '{
      {1'b1, 3'd5, 2'd1, 9'd200},
      {1'b1, 3'd2, 2'd2, 9'd400},
      {1'b1, 3'd7, 2'd3, 9'd199},
      {1'b1, 3'd0, 2'd0, 9'd401},
      {1'b0, 3'd0, 2'd1, 9'd300},
      {1'b0, 3'd0, 2'd3, 9'd511},
      {1'b1, 3'd3, 2'd2, 9'd0},
      {1'b0, 3'd0, 2'd2, 9'd201}
   };

   task automatic waitc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, int got, int exp);
      @(negedge clk);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0d exp %0d", tag, got, exp);
      end
   endtask

   task automatic chk_cfg(string tag, int em, int en, int et);
      chk({tag, " m"}, int'(m_o), em);
      chk({tag, " n"}, int'(n_o), en);
      chk({tag, " t"}, int'(t_o), et);
      chk({tag, " ratio R7"}, int'(ratio_o), 1 << en);
      chk({tag, " lock R8"}, int'(lock_err_o), (em < 200 || em > 400) ? 1 : 0);
   endtask

   task automatic shift_word(logic [13:0] w);
      for (int i = 13; i >= 0; i--) begin
         sdata_i = w[i];
         sclk_i  = 0;
         waitc(SETTLE);
         sclk_i  = 1;
         waitc(SETTLE);
      end
      sclk_i = 0;
      waitc(SETTLE);
   endtask

   task automatic pulse_sload();
      sload_i = 1;
      waitc(SETTLE);
      sload_i = 0;
      waitc(SETTLE);
   endtask

   task automatic par_load(int m, int n);
      pload_i = 0;
      waitc(SETTLE);
      m_pin_i = 9'(m);
      n_pin_i = 2'(n);
      pload_i = 1;
      waitc(SETTLE);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      waitc(3);
      rst_n = 1;
      waitc(SETTLE);
      // R9: defaults held although pload_i is high at release
      chk_cfg("R9 reset", 200, 0, 0);

      // R9: shift register cleared by reset, commit exposes zeros
      pulse_sload();
      chk_cfg("R9 cleared word", 0, 0, 0);

      // R10: undriven pins all-ones
      par_load(511, 3);
      chk_cfg("R10 undriven", 511, 3, 0);

      // R1 R2 R3 R4 R7 R8: vector walk
      for (int v = 0; v < 8; v++) begin
         if (VEC[v][14]) begin
            shift_word(VEC[v][13:0]);
            pulse_sload();
            exp_t = int'(VEC[v][13:11]);
            chk_cfg("R4 R2 serial vec", int'(VEC[v][8:0]), int'(VEC[v][10:9]), exp_t);
         end else begin
            par_load(int'(VEC[v][8:0]), int'(VEC[v][10:9]));
            chk_cfg("R3 parallel vec", int'(VEC[v][8:0]), int'(VEC[v][10:9]), exp_t);
         end
      end
      // now m=201 n=2 t=3

      // R5: serial commit ignored while pload low
      pload_i = 0;
      waitc(SETTLE);
      shift_word({3'd6, 2'd1, 9'd350});
      pulse_sload();
      chk_cfg("R5 blocked", 201, 2, 3);

      // R6: simultaneous parallel rise and serial fall
      m_pin_i = 9'd250;
      n_pin_i = 2'd0;
      sload_i = 1;
      waitc(SETTLE);
      pload_i = 1;
      sload_i = 0;
      waitc(SETTLE);
      chk_cfg("R6 priority", 250, 0, 3);
      // shifted word survived, commits now
      pulse_sload();
      chk_cfg("R6 R4 word kept", 350, 1, 6);

      // R9: reset mid-operation
      rst_n = 0;
      #2;
      checks++;
      if (m_o != 9'd200 || n_o != 2'd0 || t_o != 3'd0) begin
         fails++;
         $display("FAIL R9 async reset got %0d/%0d/%0d exp 200/0/0", m_o, n_o, t_o);
      end
      waitc(2);
      rst_n = 1;
      waitc(SETTLE);
      chk_cfg("R9 after rereset", 200, 0, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule